// File: doc/BRIEF.md
# Byte-Wide SPI Slave With Flag Handshake

This block is the receiving end of a serial peripheral link, with a small register window facing a local processor. An external master supplies the serial clock, the active-low select and the master-out data line. The block answers on the master-in line. Each transfer moves one byte in each direction, most significant bit first. The four combinations of clock idle level and sampling phase are all supported. The three serial inputs are oversampled by the system clock through two-flop synchronizers, so the system clock must run at least four times faster than the serial clock.

Software loads the next outgoing byte through the data register. It reads the byte that arrived last from a receive buffer at the same address. A completion flag in the status register, which can also raise an interrupt request, marks each finished byte. The flag is released only by a status read made while it is set, followed by a data read. Until that status read, writes to the data register are discarded. Two sticky error bits report trouble. One reports a byte that finished while the previous one was still unclaimed. The other reports a data write that arrived while a byte was on the wire.

Top module: `spis_top`

## Requirements
- R1: After reset the status, control and data reads all return 0x00, the interrupt request is 0 and the master-in line is 0.
- R2: Address 0 is the data register, address 1 the status register and address 2 the control register; address 3 reads 0x00. Control bit 0 enables the block, bit 1 sets the clock idle level, bit 2 selects the late sampling phase and bit 3 enables the interrupt; control bits 7:4 read as 0. Status bit 0 is the completion flag, bit 1 the overrun bit and bit 2 the write-collision bit; status bits 7:3 read as 0.
- R3: In every mode, a byte written while select is high goes out on the master-in line MSB first, and the byte received from the master is returned by a data read. In early phase (control bit 2 = 0), bit 7 is on the line before the first clock edge, input is sampled on the leading edge and output changes on the trailing edge. In late phase, output changes on the leading edge and input is sampled on the trailing edge. Positions vacated by shifting fill with 0.
- R4: When the eighth bit of a byte is sampled, the completion flag sets and the received byte enters the receive buffer.
- R5: The interrupt request is 1 exactly when the completion flag is 1, the interrupt enable bit is 1 and the mask input is 0.
- R6: A data read not preceded by a status read that saw the completion flag leaves the flag set. A status read that sees the flag, followed by a data read, clears it.
- R7: While the completion flag is set and no status read has seen it, a data write is discarded, leaves the outgoing byte unchanged and sets no error bit.
- R8: If a byte completes while the completion flag is still set, the overrun bit sets and the receive buffer keeps the earlier byte. The status-read-then-data-read sequence clears the overrun bit as well.
- R9: A data write while select is low in early phase, or in late phase between the first leading edge and the end of the byte, is dropped and sets the write-collision bit. A status read that sees that bit, followed by a data write, clears it.
- R10: In late phase, a data write while select is low but before the first clock edge of a byte is accepted and is the byte shifted out.
- R11: With the enable bit at 0, serial activity completes no byte and leaves the status and the receive buffer unchanged.
- R12: Raising select in the middle of a byte abandons it without completion, and the next byte is received whole from its first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 for a write access, 0 for a read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| irq_mask | input | 1 | Global interrupt mask, 1 blocks the request |
| sck_pin | input | 1 | Serial clock from the master |
| ss_n_pin | input | 1 | Active-low select from the master |
| mosi_pin | input | 1 | Serial data from the master |
| miso_pin | output | 1 | Serial data to the master |
| irq | output | 1 | Interrupt request |

## Verification
The hardest conditions to reach are the error cases, because each one depends on where a register access falls relative to the serial activity and to the handshake state. For overrun, the bench runs two whole bytes back to back and claims neither. For write collision, it pulls select low by hand with the clock idle and issues a write, then runs the byte to show the earlier byte still went out. It repeats that window in late phase, where the same write must instead be accepted. For the discarded write, the bench issues the write while the flag is unclaimed. It then shows through the master-in line on the next byte that the zero-filled shift register, not the written value, went out.

// File: rtl/spis_pkg.sv
package spis_pkg;

  // register addresses (2-bit window)
  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_CTRL = 2'd2;

  // control word, LSB first: enable, idle level, phase, interrupt enable
  localparam int CTRL_W = 4;
  typedef struct packed {
    logic ie;
    logic cpha;
    logic cpol;
    logic en;
  } ctrl_t;

  // leading edge: first edge away from the idle level
  function automatic logic lead_edge(input logic cpol, input logic rise,
                                     input logic fall);
    return cpol ? fall : rise;
  endfunction

  function automatic logic trail_edge(input logic cpol, input logic rise,
                                      input logic fall);
    return cpol ? rise : fall;
  endfunction

  // which edge samples input and which moves output
  function automatic logic sample_edge(input logic cpha, input logic lead,
                                       input logic trail);
    return cpha ? trail : lead;
  endfunction

endpackage

// File: rtl/spis_sync.sv
module spis_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_pin,
  input  logic ss_n_pin,
  input  logic mosi_pin,
  output logic ss_n_s,
  output logic mosi_s,
  output logic sck_rise,
  output logic sck_fall
);
  // bit 2: sck, bit 1: select, bit 0: data
  localparam logic [2:0] RST_VAL = 3'b010;

  logic [STAGES-1:0][2:0] chain;
  logic                   sck_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= RST_VAL;
    else        chain[0] <= {sck_pin, ss_n_pin, mosi_pin};
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[g] <= RST_VAL;
      else        chain[g] <= chain[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_d <= 1'b0;
    else        sck_d <= chain[STAGES-1][2];
  end

  assign ss_n_s   = chain[STAGES-1][1];
  assign mosi_s   = chain[STAGES-1][0];
  assign sck_rise = chain[STAGES-1][2] & ~sck_d;
  assign sck_fall = ~chain[STAGES-1][2] & sck_d;

  // R3: the synchronized clock never shows two edges of the same kind in a row
  p_alt_edges_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sck_rise |=> !sck_rise);

endmodule

// File: rtl/spis_shift.sv
module spis_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              ss_n_s,
  input  logic              mosi_s,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  output logic              miso,
  output logic              busy,
  output logic              done_pulse,
  output logic [DATA_W-1:0] rx_byte
);
  import spis_pkg::*;

  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [CNT_W-1:0]  cnt;
  logic              active;
  logic [DATA_W-1:0] tx_q;
  logic [DATA_W-2:0] rx_q;

  // named events for the assertions
  logic running, lead, trail, smp, shf, last_bit;

  assign running  = en & ~ss_n_s;
  assign lead     = lead_edge(cpol, sck_rise, sck_fall);
  assign trail    = trail_edge(cpol, sck_rise, sck_fall);
  assign smp      = running & sample_edge(cpha, lead, trail);
  // late phase: the first leading edge only presents bit 7, already on the line
  assign shf      = running & (cpha ? (lead & active) : trail);
  assign last_bit = (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      active <= 1'b0;
      tx_q   <= '0;
      rx_q   <= '0;
    end else begin
      if (!running) begin
        cnt    <= '0;
        active <= 1'b0;
      end else begin
        if (lead) active <= 1'b1;
        if (smp) begin
          rx_q <= {rx_q[DATA_W-3:0], mosi_s};
          if (last_bit) begin
            cnt    <= '0;
            active <= 1'b0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      end
      if (shf)  tx_q <= {tx_q[DATA_W-2:0], 1'b0};
      if (load) tx_q <= load_data;
    end
  end

  assign miso       = tx_q[DATA_W-1];
  assign busy       = running & (cpha ? active : 1'b1);
  assign done_pulse = smp & last_bit;
  assign rx_byte    = {rx_q, mosi_s};

  // R12: with select high (or disabled) the bit count is back at zero next cycle
  p_idle_count_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> (cnt == '0));

  // R9: the register side never loads the shifter while a byte is on the wire
  p_no_load_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy);

  // R11: nothing completes while disabled
  p_no_done_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !done_pulse);

endmodule

// File: rtl/spis_regs.sv
module spis_regs #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              irq_mask,
  input  logic              done_pulse,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              busy,
  output logic              ctl_en,
  output logic              ctl_cpol,
  output logic              ctl_cpha,
  output logic              load,
  output logic [DATA_W-1:0] load_data,
  output logic              irq
);
  import spis_pkg::*;

  ctrl_t             ctrl_q;
  logic              flag_done, flag_ovr, flag_wcol;
  logic              arm_d, arm_w;
  logic [DATA_W-1:0] rx_buf;

  // named access events
  logic sr_rd, dr_rd, dr_wr, cr_wr, wr_block, coll, clr_d;

  assign sr_rd    = bus_en & ~bus_we & (bus_addr == ADDR_STAT);
  assign dr_rd    = bus_en & ~bus_we & (bus_addr == ADDR_DATA);
  assign dr_wr    = bus_en &  bus_we & (bus_addr == ADDR_DATA);
  assign cr_wr    = bus_en &  bus_we & (bus_addr == ADDR_CTRL);
  assign wr_block = flag_done & ~arm_d;
  assign load     = dr_wr & ~wr_block & ~busy;
  assign coll     = dr_wr & ~wr_block &  busy;
  assign clr_d    = dr_rd & arm_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      flag_done <= 1'b0;
      flag_ovr  <= 1'b0;
      flag_wcol <= 1'b0;
      arm_d     <= 1'b0;
      arm_w     <= 1'b0;
      rx_buf    <= '0;
    end else begin
      if (cr_wr) ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
      if (sr_rd && flag_done) arm_d <= 1'b1;
      if (sr_rd && flag_wcol) arm_w <= 1'b1;
      if (clr_d) begin
        flag_done <= 1'b0;
        flag_ovr  <= 1'b0;
        arm_d     <= 1'b0;
      end
      // a completion in the clearing cycle starts a fresh, unclaimed byte
      if (done_pulse) begin
        if (flag_done && !clr_d) begin
          flag_ovr <= 1'b1;
        end else begin
          flag_done <= 1'b1;
          rx_buf    <= rx_byte;
        end
      end
      if (dr_wr && arm_w) begin
        flag_wcol <= 1'b0;
        arm_w     <= 1'b0;
      end
      if (coll) flag_wcol <= 1'b1;
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      ADDR_DATA: bus_rdata = rx_buf;
      ADDR_STAT: bus_rdata = {{(DATA_W-3){1'b0}}, flag_wcol, flag_ovr, flag_done};
      ADDR_CTRL: bus_rdata = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
      default:   bus_rdata = '0;
    endcase
  end

  assign ctl_en    = ctrl_q.en;
  assign ctl_cpol  = ctrl_q.cpol;
  assign ctl_cpha  = ctrl_q.cpha;
  assign load_data = bus_wdata;
  assign irq       = flag_done & ctrl_q.ie & ~irq_mask;

  // R4: the flag only rises after the shifter reported a finished byte
  p_done_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_done) |-> $past(done_pulse));

  // R6: the flag only falls after a data read that followed a status read
  p_done_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_done) |-> ($past(dr_rd) && $past(arm_d)));

  // R8: overrun is never reported without an unclaimed byte
  p_ovr_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flag_ovr |-> flag_done);

  // R8: an overrunning byte leaves the buffer untouched
  p_keep_buf_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_pulse && flag_done && !clr_d) |=> $stable(rx_buf));

  // R9: a collision bit only rises after a data write during a busy byte
  p_wcol_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_wcol) |-> $past(dr_wr && busy));

  // R5: no request without a pending byte
  p_irq_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag_done);

endmodule

// File: rtl/spis_top.sv
module spis_top #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              irq_mask,
  input  logic              sck_pin,
  input  logic              ss_n_pin,
  input  logic              mosi_pin,
  output logic              miso_pin,
  output logic              irq
);
  logic              ss_n_s, mosi_s, sck_rise, sck_fall;
  logic              ctl_en, ctl_cpol, ctl_cpha;
  logic              load, busy, done_pulse;
  logic [DATA_W-1:0] load_data, rx_byte;

  spis_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .sck_pin  (sck_pin),
    .ss_n_pin (ss_n_pin),
    .mosi_pin (mosi_pin),
    .ss_n_s   (ss_n_s),
    .mosi_s   (mosi_s),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall)
  );

  spis_shift #(.DATA_W(DATA_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (ctl_en),
    .cpol       (ctl_cpol),
    .cpha       (ctl_cpha),
    .ss_n_s     (ss_n_s),
    .mosi_s     (mosi_s),
    .sck_rise   (sck_rise),
    .sck_fall   (sck_fall),
    .load       (load),
    .load_data  (load_data),
    .miso       (miso_pin),
    .busy       (busy),
    .done_pulse (done_pulse),
    .rx_byte    (rx_byte)
  );

  spis_regs #(.DATA_W(DATA_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_en     (bus_en),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .irq_mask   (irq_mask),
    .done_pulse (done_pulse),
    .rx_byte    (rx_byte),
    .busy       (busy),
    .ctl_en     (ctl_en),
    .ctl_cpol   (ctl_cpol),
    .ctl_cpha   (ctl_cpha),
    .load       (load),
    .load_data  (load_data),
    .irq        (irq)
  );

endmodule

// File: tb/sim_spis_top.sv
module sim_spis_top;
  localparam int H = 8;  // system clocks per serial half period

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_en, bus_we;
  logic [1:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic       irq_mask, sck, ss_n, mosi, miso, irq;
  int         checks = 0, fails = 0;
  bit         finished = 1'b0;

  always #5 clk = ~clk;

  spis_top u0 (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_mask(irq_mask), .sck_pin(sck), .ss_n_pin(ss_n), .mosi_pin(mosi),
    .miso_pin(miso), .irq(irq)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_en = 1'b0;
  endtask

  task automatic hwait();
    repeat (H) @(negedge clk);
  endtask

  // master model: n bits of mo, MSB first; returns what came back
  task automatic xfer_n(input logic cpol, input logic cpha, input logic [7:0] mo,
                        input int n, output logic [7:0] mi);
    mi = 8'h00;
    ss_n = 1'b0;
    hwait();
    for (int i = 7; i >= 8 - n; i--) begin
      if (!cpha) begin
        mosi = mo[i]; hwait();
        sck = ~cpol; mi[i] = miso; hwait();
        sck = cpol;
      end else begin
        sck = ~cpol; mosi = mo[i]; hwait();
        sck = cpol; mi[i] = miso; hwait();
      end
    end
    hwait();
    ss_n = 1'b1;
    hwait(); hwait();
  endtask

  task automatic xfer(input logic cpol, input logic cpha, input logic [7:0] mo,
                      output logic [7:0] mi);
    xfer_n(cpol, cpha, mo, 8, mi);
  endtask

  task automatic claim();
    logic [7:0] t;
    rd(2'd1, t);
    rd(2'd0, t);
  endtask

  function automatic logic [7:0] tx_pat(input int m, input int k);
    return 8'(8'h5A + m * 37 + k * 91);
  endfunction

  function automatic logic [7:0] rx_pat(input int m, input int k);
    logic [7:0] t = tx_pat(m, k);
    return {t[3:0], t[7:4]} ^ 8'h0F;
  endfunction

  initial begin
    logic [7:0] v, mi;
    rst_n = 1'b0; bus_en = 1'b0; bus_we = 1'b0; bus_addr = 2'd0; bus_wdata = 8'h00;
    irq_mask = 1'b0; sck = 1'b0; ss_n = 1'b1; mosi = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd1, v); chk("R1 status", v, 8'h00);
    rd(2'd2, v); chk("R1 control", v, 8'h00);
    rd(2'd0, v); chk("R1 data", v, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);
    chk("R1 miso", {7'd0, miso}, 8'h00);

    // R2 register map
    wr(2'd2, 8'hFF); rd(2'd2, v); chk("R2 control readback", v, 8'h0F);
    rd(2'd3, v); chk("R2 unused address", v, 8'h00);
    wr(2'd2, 8'h00);

    // R3 R4 R5 R6: all four modes, several byte patterns
    for (int m = 0; m < 4; m++) begin
      logic cp, ch;
      cp = m[0]; ch = m[1];
      sck = cp;
      hwait();
      wr(2'd2, {4'd0, 1'b1, ch, cp, 1'b1});
      for (int k = 0; k < 4; k++) begin
        wr(2'd0, tx_pat(m, k));
        xfer(cp, ch, rx_pat(m, k), mi);
        chk($sformatf("R3 miso mode %0d", m), mi, tx_pat(m, k));
        chk($sformatf("R5 irq mode %0d", m), {7'd0, irq}, 8'h01);
        rd(2'd1, v); chk($sformatf("R4 done mode %0d", m), v, 8'h01);
        rd(2'd0, v); chk($sformatf("R3 rx mode %0d", m), v, rx_pat(m, k));
        rd(2'd1, v); chk($sformatf("R6 cleared mode %0d", m), v, 8'h00);
      end
    end

    // back to idle-low early phase, interrupt enabled
    sck = 1'b0; hwait();
    wr(2'd2, 8'h09);

    // R6: data read alone leaves the flag set
    wr(2'd0, 8'h81);
    xfer(1'b0, 1'b0, 8'h42, mi);
    rd(2'd0, v); chk("R6 data read value", v, 8'h42);
    rd(2'd1, v); chk("R6 flag survives lone data read", v, 8'h01);

    // R5 masking and enable
    irq_mask = 1'b1; #1;
    chk("R5 masked", {7'd0, irq}, 8'h00);
    irq_mask = 1'b0;
    wr(2'd2, 8'h01); #1;
    chk("R5 disabled", {7'd0, irq}, 8'h00);
    wr(2'd2, 8'h09);
    claim();

    // R7: write while flag unclaimed is discarded (shifter held 0x00 after byte)
    wr(2'd0, 8'hE7);
    xfer(1'b0, 1'b0, 8'h11, mi);
    wr(2'd0, 8'hC3);
    rd(2'd1, v); chk("R7 no error bit", v, 8'h01);
    rd(2'd0, v);
    xfer(1'b0, 1'b0, 8'h22, mi);
    chk("R7 discarded write not sent", mi, 8'h00);
    claim();

    // R8 overrun keeps first byte
    wr(2'd0, 8'h3C);
    xfer(1'b0, 1'b0, 8'hA1, mi);
    xfer(1'b0, 1'b0, 8'hB2, mi);
    rd(2'd1, v); chk("R8 overrun status", v, 8'h03);
    rd(2'd0, v); chk("R8 buffer keeps first", v, 8'hA1);
    rd(2'd1, v); chk("R8 overrun cleared", v, 8'h00);

    // R9 collision in early phase: select low, clock idle
    wr(2'd0, 8'h5A);
    ss_n = 1'b0; hwait();
    wr(2'd0, 8'hFF);
    rd(2'd1, v); chk("R9 collision bit", v, 8'h04);
    xfer(1'b0, 1'b0, 8'h77, mi);
    chk("R9 dropped write not sent", mi, 8'h5A);
    rd(2'd1, v); chk("R9 status after byte", v, 8'h05);
    rd(2'd0, v);
    wr(2'd0, 8'h11);
    rd(2'd1, v); chk("R9 collision cleared", v, 8'h00);

    // R10 late phase: write with select low before any edge is accepted
    wr(2'd2, 8'h0D);
    ss_n = 1'b0; hwait();
    wr(2'd0, 8'h96);
    rd(2'd1, v); chk("R10 no collision", v, 8'h00);
    xfer(1'b0, 1'b1, 8'h69, mi);
    chk("R10 accepted byte sent", mi, 8'h96);
    rd(2'd1, v); chk("R10 status", v, 8'h01);
    rd(2'd0, v); chk("R10 rx", v, 8'h69);

    // R11 disabled block ignores traffic
    wr(2'd2, 8'h08);
    xfer(1'b0, 1'b0, 8'hD4, mi);
    rd(2'd1, v); chk("R11 status unchanged", v, 8'h00);
    rd(2'd0, v); chk("R11 buffer unchanged", v, 8'h69);

    // R12 abandoned partial byte
    wr(2'd2, 8'h09);
    xfer_n(1'b0, 1'b0, 8'hF0, 4, mi);
    rd(2'd1, v); chk("R12 no completion", v, 8'h00);
    xfer(1'b0, 1'b0, 8'h4B, mi);
    rd(2'd1, v); chk("R12 single completion", v, 8'h01);
    rd(2'd0, v); chk("R12 whole byte", v, 8'h4B);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule